// File: doc/BRIEF.md
# Two-Class Conversion Scheduler for a Shared Filter

This block decides which request class owns a single filter shared by several input channels, and which channel that filter converts. It handles two classes. Priority conversions walk through a channel mask from the lowest set bit upward. They start from a software pulse or from a hardware trigger pulse. Background conversions run on one channel picked by a selector, either once or repeatedly. Only a software pulse starts them.

The filter arithmetic lives elsewhere. It receives the active channel index, a start strobe and the busy flags. It returns a one-cycle done pulse when a result is ready. The scheduler counts a done pulse only while the active channel is enabled, because a disabled channel delivers no samples. Such a conversion stalls until the channel is enabled or the global enable drops. Completion raises a sticky end-of-conversion flag per class, which software clears. Dropping the global enable aborts everything in flight and clears all pending work.

Top module: `conv_sched`

## Requirements
- R1: After reset both busy outputs, both end-of-conversion flags and the start strobe are 0.
- R2: A pulse on injSwReq or on injTrig, with the global enable high, a non-zero injMask and no priority work pending, makes busyInj 1 on the next cycle. convStart is 1 for that one cycle.
- R3: injTrig never starts or changes a background conversion. With injMask zero, a trigger leaves both busy outputs at 0.
- R4: A background conversion uses the channel that regSel holds at the cycle of the regSwReq pulse. Later changes of regSel do not move activeChan.
- R5: Priority conversions visit the set bits of the latched mask in ascending channel order, one per counted done pulse. injEoc is set on the done pulse of the last channel, and busyInj then returns to 0.
- R6: A priority request during a continuous background sequence takes the filter on the next cycle. When the priority work finishes, the background conversion starts again from the beginning, with convStart high. A done pulse counted for priority work does not set regEoc.
- R7: A regSwReq pulse that arrives while priority work runs does not interrupt it. It is held, and the background conversion runs once the priority work finishes.
- R8: While the active channel's bit in chanEn is 0, convStall is 1 and done pulses are ignored. Enabling the channel lets the conversion complete.
- R9: With filtEn low, both classes go idle on the next cycle. All pending work is discarded without setting any end-of-conversion flag, and request pulses are ignored.
- R10: injEoc and regEoc stay at 1 until the matching clear input pulses.
- R11: In continuous mode (regCont 1 at request) a counted done pulse sets regEoc and immediately starts a new conversion on the same channel. In single mode the background class goes idle.
- R12: A priority request arriving while priority work is pending is ignored. It does not reload the mask or restart the current channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| filtEn | input | 1 | Global filter enable; low aborts all work |
| chanEn | input | NCH | Per-channel enable |
| injSwReq | input | 1 | Software pulse starting priority conversions |
| injTrig | input | 1 | Hardware trigger pulse starting priority conversions |
| injMask | input | NCH | Channels converted by a priority request |
| regSwReq | input | 1 | Software pulse starting a background conversion |
| regCont | input | 1 | 1 = continuous background mode, sampled at request |
| regSel | input | CHW | Background channel, sampled at request |
| dataDone | input | 1 | One-cycle completion pulse from the filter datapath |
| injEocClr | input | 1 | Clears injEoc |
| regEocClr | input | 1 | Clears regEoc |
| busyInj | output | 1 | Priority class owns the filter |
| busyReg | output | 1 | Background class owns the filter |
| activeChan | output | CHW | Channel currently converted |
| convStart | output | 1 | Filter must restart its accumulation this cycle |
| convStall | output | 1 | A conversion is waiting on a disabled channel |
| injEoc | output | 1 | Sticky priority end-of-conversion flag |
| regEoc | output | 1 | Sticky background end-of-conversion flag |

## Verification
The bench builds the block with the default of eight channels and a three-bit selector. This brings the top channel 7 and sparse masks such as channels 2, 5 and 7 within reach, so the ascending walk skips holes and ends on the highest index. The eight-channel width also allows one disabled channel to be tested while the others stay enabled. Preemption, the held background request and aborts are each driven at the exact cycle where two conditions meet, for example a trigger arriving in the middle of a priority walk.

// File: rtl/conv_sched_pkg.sv
package conv_sched_pkg;

  typedef enum logic [1:0] {
    OWN_IDLE = 2'd0,
    OWN_INJ  = 2'd1,
    OWN_REG  = 2'd2
  } owner_e;

  // Strobes from control to datapath, valid for one cycle.
  typedef struct packed {
    logic flush;       // global enable low: drop all work
    logic injLoad;     // latch a new priority mask
    logic injAdvance;  // current priority channel finished
    logic regDone;     // background conversion finished
    logic regLatch;    // sample background channel select
  } sched_strobe_t;

endpackage

// File: rtl/conv_sched_ctrl.sv
module conv_sched_ctrl
  import conv_sched_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CHW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          filtEn,
  input  logic          injSwReq,
  input  logic          injTrig,
  input  logic          injMaskAny,
  input  logic          regSwReq,
  input  logic          regCont,
  input  logic          dataDone,
  input  logic          injPendAny,
  input  logic          chanOk,
  input  logic [CHW-1:0] activeChan,
  output sched_strobe_t st,
  output owner_e        owner,
  output logic          convStart
);

  logic regPend, regContQ;
  owner_e prevOwner;
  logic [CHW-1:0] prevChan;
  logic prevDone;
  logic doneOk;

  // Priority decode: pending priority work always wins the filter.
  always_comb begin
    if (!filtEn)         owner = OWN_IDLE;
    else if (injPendAny) owner = OWN_INJ;
    else if (regPend)    owner = OWN_REG;
    else                 owner = OWN_IDLE;
  end

  assign doneOk = dataDone && chanOk && (owner != OWN_IDLE);

  always_comb begin
    st.flush      = !filtEn;
    st.injLoad    = filtEn && (injSwReq || injTrig) && injMaskAny && !injPendAny;
    st.injAdvance = doneOk && (owner == OWN_INJ);
    st.regDone    = doneOk && (owner == OWN_REG);
    st.regLatch   = filtEn && regSwReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regPend  <= 1'b0;
      regContQ <= 1'b0;
    end else if (st.flush) begin
      regPend  <= 1'b0;
      regContQ <= 1'b0;
    end else if (st.regLatch) begin
      regPend  <= 1'b1;
      regContQ <= regCont;
    end else if (st.regDone && !regContQ) begin
      regPend  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevOwner <= OWN_IDLE;
      prevChan  <= '0;
      prevDone  <= 1'b0;
    end else begin
      prevOwner <= owner;
      prevChan  <= activeChan;
      prevDone  <= doneOk;
    end
  end

  // New owner, new channel, or a fresh run after completion: restart the filter.
  assign convStart = (owner != OWN_IDLE) &&
                     ((owner != prevOwner) || (activeChan != prevChan) || prevDone);

  a_r9_disable_idles: assert property (@(posedge clk) disable iff (!rstN)
    !filtEn |=> (owner == OWN_IDLE));

  a_r3_trig_no_reg: assert property (@(posedge clk) disable iff (!rstN)
    (!regPend && !regSwReq) |=> !regPend);

  a_r8_stall_holds: assert property (@(posedge clk) disable iff (!rstN)
    ((owner == OWN_REG) && !chanOk && filtEn) |=> regPend);

endmodule

// File: rtl/conv_sched_dp.sv
module conv_sched_dp
  import conv_sched_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rstN,
  input  sched_strobe_t  st,
  input  owner_e         owner,
  input  logic [NCH-1:0] injMask,
  input  logic [CHW-1:0] regSel,
  input  logic [NCH-1:0] chanEn,
  input  logic           injEocClr,
  input  logic           regEocClr,
  output logic           injPendAny,
  output logic [CHW-1:0] activeChan,
  output logic           chanOk,
  output logic           injEoc,
  output logic           regEoc
);

  logic [NCH-1:0] injRemain, injNext;
  logic [CHW-1:0] injChan, regChanQ;

  // Lowest set bit of the remaining mask.
  always_comb begin
    injChan = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (injRemain[i]) injChan = CHW'(i);
    end
  end

  assign injNext    = injRemain & ~(NCH'(1) << injChan);
  assign injPendAny = |injRemain;
  assign activeChan = (owner == OWN_REG) ? regChanQ : injChan;
  assign chanOk     = chanEn[activeChan];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              injRemain <= '0;
    else if (st.flush)      injRemain <= '0;
    else if (st.injLoad)    injRemain <= injMask;
    else if (st.injAdvance) injRemain <= injNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            regChanQ <= '0;
    else if (st.regLatch) regChanQ <= regSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      injEoc <= 1'b0;
      regEoc <= 1'b0;
    end else begin
      if (st.injAdvance && (injNext == '0)) injEoc <= 1'b1;
      else if (injEocClr)                   injEoc <= 1'b0;
      if (st.regDone)                       regEoc <= 1'b1;
      else if (regEocClr)                   regEoc <= 1'b0;
    end
  end

  a_r12_inj_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (injPendAny && !st.flush && !st.injAdvance) |=> $stable(injRemain));

  a_r10_inj_eoc_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (injEoc && !injEocClr) |=> injEoc);

  a_r10_reg_eoc_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (regEoc && !regEocClr) |=> regEoc);

endmodule

// File: rtl/conv_sched.sv
module conv_sched
  import conv_sched_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           filtEn,
  input  logic [NCH-1:0] chanEn,
  input  logic           injSwReq,
  input  logic           injTrig,
  input  logic [NCH-1:0] injMask,
  input  logic           regSwReq,
  input  logic           regCont,
  input  logic [CHW-1:0] regSel,
  input  logic           dataDone,
  input  logic           injEocClr,
  input  logic           regEocClr,
  output logic           busyInj,
  output logic           busyReg,
  output logic [CHW-1:0] activeChan,
  output logic           convStart,
  output logic           convStall,
  output logic           injEoc,
  output logic           regEoc
);

  sched_strobe_t st;
  owner_e owner;
  logic injPendAny, chanOk;

  conv_sched_ctrl #(.NCH(NCH)) ctrl_i (
    .clk(clk), .rstN(rstN), .filtEn(filtEn),
    .injSwReq(injSwReq), .injTrig(injTrig), .injMaskAny(|injMask),
    .regSwReq(regSwReq), .regCont(regCont), .dataDone(dataDone),
    .injPendAny(injPendAny), .chanOk(chanOk), .activeChan(activeChan),
    .st(st), .owner(owner), .convStart(convStart)
  );

  conv_sched_dp #(.NCH(NCH)) dp_i (
    .clk(clk), .rstN(rstN), .st(st), .owner(owner),
    .injMask(injMask), .regSel(regSel), .chanEn(chanEn),
    .injEocClr(injEocClr), .regEocClr(regEocClr),
    .injPendAny(injPendAny), .activeChan(activeChan), .chanOk(chanOk),
    .injEoc(injEoc), .regEoc(regEoc)
  );

  assign busyInj   = (owner == OWN_INJ);
  assign busyReg   = (owner == OWN_REG);
  assign convStall = (owner != OWN_IDLE) && !chanOk;

endmodule

// File: tb/conv_sched_tb_top.sv
module conv_sched_tb_top;
  localparam int NCH = 8;
  localparam int CHW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic filtEn = 1'b0;
  logic [NCH-1:0] chanEn = '1;
  logic injSwReq = 1'b0, injTrig = 1'b0, regSwReq = 1'b0, regCont = 1'b0;
  logic [NCH-1:0] injMask = '0;
  logic [CHW-1:0] regSel = '0;
  logic dataDone = 1'b0, injEocClr = 1'b0, regEocClr = 1'b0;
  logic busyInj, busyReg, convStart, convStall, injEoc, regEoc;
  logic [CHW-1:0] activeChan;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  conv_sched #(.NCH(NCH)) dut_i (
    .clk(clk), .rstN(rstN), .filtEn(filtEn), .chanEn(chanEn),
    .injSwReq(injSwReq), .injTrig(injTrig), .injMask(injMask),
    .regSwReq(regSwReq), .regCont(regCont), .regSel(regSel),
    .dataDone(dataDone), .injEocClr(injEocClr), .regEocClr(regEocClr),
    .busyInj(busyInj), .busyReg(busyReg), .activeChan(activeChan),
    .convStart(convStart), .convStall(convStall), .injEoc(injEoc), .regEoc(regEoc)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulseDone();
    dataDone = 1'b1; tick(); dataDone = 1'b0;
  endtask

  task automatic clearEoc();
    injEocClr = 1'b1; regEocClr = 1'b1; tick();
    injEocClr = 1'b0; regEocClr = 1'b0;
  endtask

  task automatic testReset();
    check("R1", "busyInj", busyInj, 0);
    check("R1", "busyReg", busyReg, 0);
    check("R1", "injEoc", injEoc, 0);
    check("R1", "regEoc", regEoc, 0);
    check("R1", "convStart", convStart, 0);
  endtask

  task automatic testInjWalk();
    injMask = 8'b1010_0100;
    injSwReq = 1'b1; tick(); injSwReq = 1'b0;
    check("R2", "busyInj", busyInj, 1);
    check("R2", "convStart", convStart, 1);
    check("R5", "first chan", activeChan, 2);
    tick();
    check("R2", "convStart one cycle", convStart, 0);
    pulseDone();
    check("R5", "second chan", activeChan, 5);
    check("R5", "restart", convStart, 1);
    check("R5", "no early eoc", injEoc, 0);
    pulseDone();
    check("R5", "third chan", activeChan, 7);
    pulseDone();
    check("R5", "idle after last", busyInj, 0);
    check("R5", "injEoc", injEoc, 1);
    tick(); tick();
    check("R10", "injEoc sticky", injEoc, 1);
    injEocClr = 1'b1; tick(); injEocClr = 1'b0;
    check("R10", "injEoc cleared", injEoc, 0);
  endtask

  task automatic testTrigger();
    injMask = '0; regSel = 3'd3;
    injTrig = 1'b1; tick(); injTrig = 1'b0;
    check("R3", "trig no reg", busyReg, 0);
    check("R3", "trig empty mask", busyInj, 0);
    injMask = 8'h80;
    injTrig = 1'b1; tick(); injTrig = 1'b0;
    check("R2", "trig starts inj", busyInj, 1);
    check("R2", "trig chan", activeChan, 7);
    check("R3", "trig no reg busy", busyReg, 0);
    pulseDone();
    check("R3", "no reg after inj", busyReg, 0);
    check("R3", "regEoc untouched", regEoc, 0);
    clearEoc();
  endtask

  task automatic testRegSingle();
    regSel = 3'd6; regCont = 1'b0;
    regSwReq = 1'b1; tick(); regSwReq = 1'b0;
    check("R4", "busyReg", busyReg, 1);
    check("R4", "chan", activeChan, 6);
    check("R4", "convStart", convStart, 1);
    regSel = 3'd1; tick();
    check("R4", "chan latched", activeChan, 6);
    pulseDone();
    check("R11", "single idles", busyReg, 0);
    check("R11", "regEoc", regEoc, 1);
    clearEoc();
  endtask

  task automatic testContPreempt();
    regSel = 3'd4; regCont = 1'b1;
    regSwReq = 1'b1; tick(); regSwReq = 1'b0;
    check("R11", "cont chan", activeChan, 4);
    tick();
    pulseDone();
    check("R11", "cont regEoc", regEoc, 1);
    check("R11", "cont still busy", busyReg, 1);
    check("R11", "cont restart", convStart, 1);
    regEocClr = 1'b1; tick(); regEocClr = 1'b0;
    injMask = 8'h01;
    injSwReq = 1'b1; tick(); injSwReq = 1'b0;
    check("R6", "inj takes over", busyInj, 1);
    check("R6", "reg paused", busyReg, 0);
    check("R6", "inj chan", activeChan, 0);
    check("R6", "inj start", convStart, 1);
    pulseDone();
    check("R6", "reg resumes", busyReg, 1);
    check("R6", "resume chan", activeChan, 4);
    check("R6", "resume restart", convStart, 1);
    check("R6", "no regEoc from inj", regEoc, 0);
    filtEn = 1'b0; tick();
    check("R9", "abort idle", busyReg, 0);
    filtEn = 1'b1; tick();
    check("R9", "pending dropped", busyReg, 0);
    clearEoc();
  endtask

  task automatic testHeldReq();
    injMask = 8'h06;
    injSwReq = 1'b1; tick(); injSwReq = 1'b0;
    check("R7", "inj chan", activeChan, 1);
    regSel = 3'd5; regCont = 1'b0;
    regSwReq = 1'b1; tick(); regSwReq = 1'b0;
    check("R7", "inj not interrupted", busyInj, 1);
    check("R7", "chan kept", activeChan, 1);
    injMask = 8'h80;
    injTrig = 1'b1; tick(); injTrig = 1'b0;
    check("R12", "no restart", activeChan, 1);
    check("R12", "no start strobe", convStart, 0);
    pulseDone();
    check("R12", "mask kept", activeChan, 2);
    pulseDone();
    check("R7", "inj done", busyInj, 0);
    check("R7", "held reg runs", busyReg, 1);
    check("R7", "held chan", activeChan, 5);
    pulseDone();
    check("R7", "reg finished", regEoc, 1);
    clearEoc();
  endtask

  task automatic testStall();
    chanEn = 8'hFB;
    regSel = 3'd2; regCont = 1'b0;
    regSwReq = 1'b1; tick(); regSwReq = 1'b0;
    check("R8", "stall flag", convStall, 1);
    pulseDone();
    check("R8", "done ignored busy", busyReg, 1);
    check("R8", "done ignored eoc", regEoc, 0);
    chanEn = 8'hFF; tick();
    check("R8", "stall released", convStall, 0);
    pulseDone();
    check("R8", "completes", regEoc, 1);
    clearEoc();
    chanEn = 8'hF7; injMask = 8'h08;
    injSwReq = 1'b1; tick(); injSwReq = 1'b0;
    check("R8", "inj stall", convStall, 1);
    filtEn = 1'b0; tick();
    filtEn = 1'b1; tick();
    check("R9", "stall aborted", busyInj, 0);
    check("R9", "no eoc on abort", injEoc, 0);
    chanEn = 8'hFF; filtEn = 1'b0;
    regSwReq = 1'b1; injSwReq = 1'b1; tick();
    regSwReq = 1'b0; injSwReq = 1'b0; filtEn = 1'b1; tick();
    check("R9", "req ignored reg", busyReg, 0);
    check("R9", "req ignored inj", busyInj, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tick(); tick();
    rstN = 1'b1;
    tick();
    testReset();
    filtEn = 1'b1;
    tick();
    testInjWalk();
    testTrigger();
    testRegSingle();
    testContPreempt();
    testHeldReq();
    testStall();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule